// File: doc/BRIEF.md
# Box and Single Command List DMA Executor

This block moves data on behalf of software by walking a list of commands held in memory. Software writes the start register with the byte address of a pointer entry, shifted right by three. The block reads that pointer entry, follows it to an 8-byte-aligned command list, and executes the commands one after another. Every command is carried out as 32-bit word reads followed by word writes on a single request/acknowledge memory port.

A single command copies a contiguous run of bytes. A box command moves a two-dimensional block. Each of its row-length, row-count and row-stride words carries the source value in the upper half and the destination value in the lower half. Either side of a command may be tied to a peripheral request line, and the block then waits for that line's ready input before each word on that side. The block reports a done pulse when the final list ends. It reports an error pulse on an unknown command type or on a bus error.

Top module: `cmdlist_dma`

## Requirements
- R1: After reset, busy, done, error and mem_req are all 0, and no memory request is made while busy is 0.
- R2: A start pulse while idle makes the block read the pointer entry at byte address start_ptr*8. Bits [28:0] of that entry, times 8, give the command list address.
- R3: A single command (bits [2:0] = 0) occupies 4 words: command, source, destination and byte length in bits [15:0]. It copies length/4 words with both addresses rising by 4. A memory request holds its address until acknowledged.
- R4: A box command (bits [2:0] = 3) occupies 6 words: command, source, destination, row length, row count and row stride. In the last three words, bits [31:16] belong to the source and bits [15:0] to the destination. At the end of each row, that side's address becomes its row start plus its stride.
- R5: A box side with a 4-byte row and a stride of 0 reads or writes one fixed address for every row.
- R6: Command bit 31 marks the last command of a list. Otherwise the next command begins immediately after the current one, 16 bytes on for single and 24 bytes on for box.
- R7: When the pointer entry's bit 31 is clear, the next pointer entry is read 4 bytes on once the current list ends.
- R8: Command bits [6:3] select the source ready line and bits [10:7] the destination ready line, with 0 meaning none. A word on a side with a selected line is not requested until fc_ready of that line is 1.
- R9: When the list of a pointer entry with bit 31 set ends, done pulses for one cycle and busy is 0 in that same cycle.
- R10: A command type other than 0 or 3 raises a one-cycle error pulse, makes no data transfer and returns the block to idle.
- R11: A bus error on any acknowledged access raises error, stops execution and gives no done.
- R12: A start pulse while busy is ignored.
- R13: A zero length, or a zero source row count or row length, makes no data access, and execution moves on to the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| start_ptr | input | AW | Pointer entry byte address shifted right by 3 |
| fc_ready | input | FC_LINES | Per-request-line ready inputs; line 0 unused |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Executing a list |
| done | output | 1 | One-cycle pulse: execution finished |
| error | output | 1 | One-cycle pulse: execution aborted |

## Verification
The assertions take for granted that mem_ack only comes while a request is pending and that mem_err is only meaningful with mem_ack. They also assume that all addresses, lengths and strides are multiples of 4, and that each box command moves the same number of words on its source side as on its destination side. The bench memory model acknowledges exactly one cycle after it sees a fresh request. Every command list is built by hand with word-aligned values and with matching source and destination totals.

// File: rtl/cmdlist_dma.sv
module cmdlist_dma #(
  parameter int AW = 32,
  parameter int FC_LINES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       start_ptr,
  input  logic [FC_LINES-1:0] fc_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [31:0]         mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                error
);
  localparam int PW = AW - 3;

  typedef enum logic [2:0] {S_IDLE, S_PTR, S_FETCH, S_NEXT, S_RFC, S_RD, S_WFC, S_WR} st_t;
  st_t st;

  logic [AW-1:0] ptr_addr, list_addr;
  logic          lp_last;
  logic [2:0]    widx;
  logic [31:0]   cmd, w3, w4, wbuf;
  logic [AW-1:0] a_addr [2];
  logic [AW-1:0] a_row  [2];
  logic [15:0]   a_off  [2];
  logic [15:0]   a_rows [2];
  logic [13:0]   a_len  [2];
  logic [13:0]   a_col  [2];
  logic [1:0]    step;

  logic [15:0] fc_all;
  assign fc_all = 16'(fc_ready);
  wire fc_src_ok = (cmd[6:3] == 4'd0) || fc_all[cmd[6:3]];
  wire fc_dst_ok = (cmd[10:7] == 4'd0) || fc_all[cmd[10:7]];
  wire is_box    = (cmd[2:0] == 3'd3);
  wire acc_ok    = mem_ack && !mem_err;
  wire last_word = (widx == 3'd5) || (widx == 3'd3 && !is_box);
  wire no_work   = is_box ? (w3[31:18] == 14'd0 || w4[31:16] == 16'd0) : (mem_rdata[15:2] == 14'd0);

  assign step[0] = (st == S_RD) && acc_ok;
  assign step[1] = (st == S_WR) && acc_ok;

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_PTR) || (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = wbuf;
  always_comb begin
    case (st)
      S_PTR:   mem_addr = ptr_addr;
      S_FETCH: mem_addr = list_addr;
      S_RD:    mem_addr = a_addr[0];
      S_WR:    mem_addr = a_addr[1];
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; error <= 1'b0;
      ptr_addr <= '0; list_addr <= '0; lp_last <= 1'b0; widx <= '0;
      cmd <= '0; w3 <= '0; w4 <= '0; wbuf <= '0;
      for (int s = 0; s < 2; s++) begin
        a_addr[s] <= '0; a_row[s] <= '0; a_off[s] <= '0;
        a_rows[s] <= '0; a_len[s] <= '0; a_col[s] <= '0;
      end
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        if (step[s]) begin
          if (a_col[s] == 14'd1) begin
            a_rows[s] <= a_rows[s] - 16'd1;
            a_row[s]  <= a_row[s] + AW'(a_off[s]);
            a_addr[s] <= a_row[s] + AW'(a_off[s]);
            a_col[s]  <= a_len[s];
          end else begin
            a_addr[s] <= a_addr[s] + AW'(4);
            a_col[s]  <= a_col[s] - 14'd1;
          end
        end
      end
      if (mem_req && mem_ack && mem_err) begin
        error <= 1'b1;
        st    <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            ptr_addr <= {start_ptr[PW-1:0], 3'b000};
            st <= S_PTR;
          end
          S_PTR: if (mem_ack) begin
            lp_last   <= mem_rdata[31];
            list_addr <= {AW'(mem_rdata[28:0])} << 3;
            widx      <= '0;
            st        <= S_FETCH;
          end
          S_FETCH: if (mem_ack) begin
            list_addr <= list_addr + AW'(4);
            widx      <= widx + 3'd1;
            case (widx)
              3'd0: begin
                cmd <= mem_rdata;
                if (mem_rdata[2:0] != 3'd0 && mem_rdata[2:0] != 3'd3) begin
                  error <= 1'b1;
                  st    <= S_IDLE;
                end
              end
              3'd1: begin a_addr[0] <= mem_rdata[AW-1:0]; a_row[0] <= mem_rdata[AW-1:0]; end
              3'd2: begin a_addr[1] <= mem_rdata[AW-1:0]; a_row[1] <= mem_rdata[AW-1:0]; end
              3'd3: w3 <= mem_rdata;
              3'd4: w4 <= mem_rdata;
              default: ;
            endcase
            if (last_word) begin
              if (is_box) begin
                a_len[0] <= w3[31:18]; a_col[0] <= w3[31:18];
                a_len[1] <= w3[15:2];  a_col[1] <= w3[15:2];
                a_rows[0] <= w4[31:16]; a_rows[1] <= w4[15:0];
                a_off[0] <= mem_rdata[31:16]; a_off[1] <= mem_rdata[15:0];
              end else begin
                a_len[0] <= mem_rdata[15:2]; a_col[0] <= mem_rdata[15:2];
                a_len[1] <= mem_rdata[15:2]; a_col[1] <= mem_rdata[15:2];
                a_rows[0] <= 16'd1; a_rows[1] <= 16'd1;
                a_off[0] <= '0; a_off[1] <= '0;
              end
              st <= no_work ? S_NEXT : S_RFC;
            end
          end
          S_NEXT: begin
            widx <= '0;
            if (!cmd[31]) st <= S_FETCH;
            else if (lp_last) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              ptr_addr <= ptr_addr + AW'(4);
              st <= S_PTR;
            end
          end
          S_RFC: if (fc_src_ok) st <= S_RD;
          S_RD: if (mem_ack) begin
            wbuf <= mem_rdata;
            st   <= S_WFC;
          end
          S_WFC: if (fc_dst_ok) st <= S_WR;
          S_WR: if (mem_ack) st <= (a_rows[0] == 16'd0) ? S_NEXT : S_RFC;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdlist_dma_chk.sv
module cmdlist_dma_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_error_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy);
  assert_no_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
endmodule

bind cmdlist_dma cmdlist_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_cmdlist_dma.sv
`timescale 1ns/1ps
module sim_cmdlist_dma;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_ptr = '0;
  logic [15:0] fc_ready = '0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0, busy, done, error;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int rd_data = 0, wr_cnt = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmdlist_dma u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .fc_ready(fc_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .error(error));

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= (mem_addr == err_addr);
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_addr >= 32'h100) rd_data <= rd_data + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] src_v(input int byte_a); return 32'hA000_0000 + byte_a / 4; endfunction
  function automatic logic [31:0] dst_v(input int byte_a); return 32'hDEAD_0000 + byte_a / 4; endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64 && i < 128) ? 32'hA000_0000 + i : 32'hDEAD_0000 + i;
  endtask
  task automatic put(input int a, input logic [31:0] v); mem[a / 4] = v; endtask
  task automatic put_single(input int a, input logic [31:0] c, input int s, input int d, input int len);
    put(a, c); put(a + 4, s); put(a + 8, d); put(a + 12, len);
  endtask

  task automatic pulse_start(input int byte_a);
    @(negedge clk); start = 1; start_ptr = byte_a / 8;
    @(negedge clk); start = 0;
  endtask
  task automatic wait_end(output bit d, output bit e);
    d = 0; e = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) d = 1;
      if (error) e = 1;
      if (!busy) break;
    end
  endtask
  task automatic run(input int byte_a, output bit d, output bit e);
    pulse_start(byte_a); wait_end(d, e);
  endtask

  task automatic t_reset();
    check(!busy && !done && !error && !mem_req, "R1 reset state", {busy, done, error, mem_req}, 0);
  endtask

  task automatic t_single();
    bit d, e;
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0000, 32'h100, 32'h200, 16);
    run(0, d, e);
    check(d && !e, "R9 done after single", {d, e}, 2'b10);
    for (int j = 0; j < 4; j++)
      check(mem[128 + j] == src_v(32'h100 + 4 * j), "R2 R3 single copy", mem[128 + j], src_v(32'h100 + 4 * j));
    check(mem[132] == dst_v(32'h210), "R3 single length bound", mem[132], dst_v(32'h210));
  endtask

  task automatic t_box();
    bit d, e;
    int sa [6] = '{32'h100, 32'h104, 32'h110, 32'h114, 32'h120, 32'h124};
    clear_mem();
    put(0, 32'h8000_0008);
    put(32'h40, 32'h8000_0003); put(32'h44, 32'h100); put(32'h48, 32'h200);
    put(32'h4C, (8 << 16) | 8); put(32'h50, (3 << 16) | 3); put(32'h54, (16 << 16) | 8);
    run(0, d, e);
    check(d && !e, "R4 box done", {d, e}, 2'b10);
    for (int j = 0; j < 6; j++)
      check(mem[128 + j] == src_v(sa[j]), "R4 box row stride", mem[128 + j], src_v(sa[j]));
    check(mem[134] == dst_v(32'h218), "R4 box end", mem[134], dst_v(32'h218));
  endtask

  task automatic t_fixed();
    bit d, e;
    int w0;
    clear_mem();
    put(0, 32'h8000_0008);
    put(32'h40, 32'h8000_0003); put(32'h44, 32'h100); put(32'h48, 32'h2F0);
    put(32'h4C, (16 << 16) | 4); put(32'h50, (1 << 16) | 4); put(32'h54, 0);
    w0 = wr_cnt;
    run(0, d, e);
    check(mem[188] == src_v(32'h10C), "R5 fixed address last word", mem[188], src_v(32'h10C));
    check(mem[189] == dst_v(32'h2F4), "R5 fixed address no advance", mem[189], dst_v(32'h2F4));
    check(wr_cnt - w0 == 4, "R5 write count", wr_cnt - w0, 4);
  endtask

  task automatic t_chain();
    bit d, e;
    clear_mem();
    put(0, 32'h0000_0008); put(4, 32'h8000_0010);
    put_single(32'h40, 32'h0, 32'h100, 32'h200, 8);
    put_single(32'h50, 32'h8000_0000, 32'h120, 32'h220, 4);
    put_single(32'h80, 32'h8000_0000, 32'h140, 32'h240, 4);
    run(0, d, e);
    check(d && !e, "R9 chain done", {d, e}, 2'b10);
    check(mem[129] == src_v(32'h104), "R6 first command", mem[129], src_v(32'h104));
    check(mem[136] == src_v(32'h120), "R6 second command follows", mem[136], src_v(32'h120));
    check(mem[144] == src_v(32'h140), "R7 next pointer entry", mem[144], src_v(32'h140));
  endtask

  task automatic t_fc();
    bit d, e;
    int r0, w0;
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0000 | (5 << 3), 32'h100, 32'h200, 8);
    fc_ready = '0; r0 = rd_data;
    pulse_start(0);
    repeat (30) @(negedge clk);
    check(rd_data == r0 && busy, "R8 source waits for ready", rd_data - r0, 0);
    fc_ready[5] = 1;
    wait_end(d, e);
    check(d && mem[129] == src_v(32'h104), "R8 source released", mem[129], src_v(32'h104));
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0000 | (9 << 7), 32'h100, 32'h200, 8);
    fc_ready = '0; r0 = rd_data; w0 = wr_cnt;
    pulse_start(0);
    repeat (30) @(negedge clk);
    check(rd_data - r0 == 1 && wr_cnt == w0, "R8 destination waits for ready", wr_cnt - w0, 0);
    fc_ready[9] = 1;
    wait_end(d, e);
    check(d && mem[129] == src_v(32'h104), "R8 destination released", mem[129], src_v(32'h104));
    fc_ready = '0;
  endtask

  task automatic t_badtype();
    bit d, e;
    int w0;
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0002, 32'h100, 32'h200, 8);
    w0 = wr_cnt;
    run(0, d, e);
    check(e && !d && !busy, "R10 bad type error", {d, e}, 2'b01);
    check(wr_cnt == w0, "R10 no transfer", wr_cnt - w0, 0);
  endtask

  task automatic t_buserr();
    bit d, e;
    int w0;
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0000, 32'h100, 32'h200, 16);
    err_addr = 32'h104; w0 = wr_cnt;
    run(0, d, e);
    err_addr = 32'hFFFF_FFFF;
    check(e && !d, "R11 bus error", {d, e}, 2'b01);
    check(wr_cnt - w0 == 1 && mem[129] == dst_v(32'h204), "R11 stops", wr_cnt - w0, 1);
  endtask

  task automatic t_zero();
    bit d, e;
    int r0, w0;
    clear_mem();
    put(0, 32'h8000_0008);
    put_single(32'h40, 32'h8000_0000, 32'h100, 32'h200, 0);
    r0 = rd_data; w0 = wr_cnt;
    run(0, d, e);
    check(d && !e, "R13 zero length done", {d, e}, 2'b10);
    check(rd_data == r0 && wr_cnt == w0, "R13 no access", wr_cnt - w0, 0);
  endtask

  task automatic t_busy();
    bit d, e;
    clear_mem();
    put(0, 32'h8000_0008); put(8, 32'h8000_0018);
    put_single(32'h40, 32'h8000_0000 | (5 << 3), 32'h100, 32'h200, 8);
    put_single(32'hC0, 32'h8000_0000, 32'h140, 32'h280, 8);
    fc_ready = '0;
    pulse_start(0);
    repeat (10) @(negedge clk);
    pulse_start(8);
    repeat (10) @(negedge clk);
    fc_ready = '1;
    wait_end(d, e);
    fc_ready = '0;
    check(d && mem[128] == src_v(32'h100), "R12 first run completes", mem[128], src_v(32'h100));
    check(mem[160] == dst_v(32'h280), "R12 start while busy ignored", mem[160], dst_v(32'h280));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_box();
    t_fixed();
    t_chain();
    t_fc();
    t_badtype();
    t_buserr();
    t_zero();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule